// File: doc/BRIEF.md
# GPIO Companion Register Block

This block is a small peripheral on a plain synchronous register bus. The bus has an address, a write strobe, write data and combinational read data. The block holds eight 16-bit control words that software can store and read back: mode, clock divide, status, power, clock control and three interrupt words. It also holds a direction word and a GPIO level word. The control words have no function inside the block; other logic uses them. The status word is fixed. A write to the power word with bit 7 set also forces two more bits to one.

The level word connects software to 16 GPIO pins:
- Bus writes to the level word are masked by the direction word.
- Each input pin, after synchronization, copies a change of its state into its own level bit.
- The output pins show level AND direction. The block latches this vector again only when software writes the direction or level word. Between such writes, a level change caused by an input pin stays invisible on the outputs.

Top module: `gpio_companion_regs`

## Requirements
- R1: After reset every decoded offset reads 0x0000, except status (offset 0x08), which reads 0x0002. `gpio_out` is 0x0000.
- R2: Only address bits [5:0] are decoded. An address whose low six bits match a register offset reaches that register.
- R3: Offsets 0x00, 0x04, 0x10, 0x14, 0x18 and 0x1C store bits [15:0] of the write data and read them back. Bits [31:16] are discarded.
- R4: A write to offset 0x0C stores the written value. If bit 7 of that value is 1, the stored value is also ORed with 0x8040.
- R5: Offset 0x08 always reads 0x0002, and writes to it change nothing.
- R6: Offset 0x20 stores the direction word. A write to offset 0x24 or 0x28 stores (write data AND direction) into the level word. Both offsets read the level word.
- R7: After the clock edge that takes a direction write or a level write, `gpio_out` equals level AND direction.
- R8: `gpio_out` holds its value in every cycle that has no direction write and no level write, including when the level word changes because of an input pin.
- R9: When a synchronized `gpio_in[i]` changes state, level bit i takes the new pin state. This update is not masked by direction. It appears on the read port on the third rising edge after the pin changes.
- R10: If a bus write to a level offset and an input-driven update fall on the same edge, the bus write wins and that input change is dropped.
- R11: Reads of undecoded offsets return 0x0000 and writes to them change no register. Undecoded offsets are offsets that are not a multiple of 4, and offsets 0x2C to 0x3F.
- R12: A direction write leaves the stored level word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (12) | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W (32) | Write data; only bits [15:0] are used |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| gpio_in | input | 16 | Asynchronous GPIO input pins |
| gpio_out | output | 16 | Latched GPIO output pins |

## Verification
A wrong level word shows at the read port in the cycle after the write or pin update that caused it. On the pins it shows only after the next direction or level write. The bench therefore reads the level word directly, and it also reads `gpio_out` right after each refresh write. A stale previous-output register, or a refresh that fires too often, is caught by reading `gpio_out` after an input change with no bus write, because the outputs must not follow. The same-edge collision between a bus write and an input update is placed exactly on the third edge after the pin changes, so that an extra or missing synchronizer stage moves the collision and changes the level that is read back.

// File: rtl/gcr_pkg.sv
package gcr_pkg;
  localparam int REG_W     = 16;
  localparam int NUM_CTRL  = 8;
  localparam int NUM_SLOTS = 11;
  localparam int SLOT_W    = 4;

  // word slots = byte offset / 4
  localparam int SLOT_STATUS  = 2;
  localparam int SLOT_POWER   = 3;
  localparam int SLOT_DIR     = 8;
  localparam int SLOT_LEVEL_A = 9;
  localparam int SLOT_LEVEL_B = 10;

  localparam logic [REG_W-1:0] STATUS_VALUE = 16'h0002;
  localparam int               PWR_TRIG_BIT = 7;
  localparam logic [REG_W-1:0] PWR_FORCE    = 16'h8040;

  function automatic logic [REG_W-1:0] power_fix(input logic [REG_W-1:0] v);
    return v[PWR_TRIG_BIT] ? (v | PWR_FORCE) : v;
  endfunction

  function automatic logic [REG_W-1:0] dir_mask(input logic [REG_W-1:0] lvl,
                                                input logic [REG_W-1:0] dir);
    return lvl & dir;
  endfunction

  // replace only the bits flagged in chg with the pin state
  function automatic logic [REG_W-1:0] apply_edges(input logic [REG_W-1:0] lvl,
                                                   input logic [REG_W-1:0] pins,
                                                   input logic [REG_W-1:0] chg);
    return (lvl & ~chg) | (pins & chg);
  endfunction
endpackage

// File: rtl/gcr_sync.sv
module gcr_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      st_q[0] <= din;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign dout = st_q[STAGES-1];
endmodule

// File: rtl/gcr_decode.sv
module gcr_decode
  import gcr_pkg::*;
(
  input  logic [5:0]           off,
  input  logic                 we,
  output logic                 hit,
  output logic [SLOT_W-1:0]    slot,
  output logic [NUM_SLOTS-1:0] wr_slot
);
  logic aligned;

  assign aligned = (off[1:0] == 2'b00);
  assign slot    = off[5:2];
  assign hit     = aligned && (slot < SLOT_W'(NUM_SLOTS));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_wr
    assign wr_slot[i] = we && hit && (slot == SLOT_W'(i));
  end
endmodule

// File: rtl/gcr_ctrl_regs.sv
module gcr_ctrl_regs
  import gcr_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CTRL-1:0]           wr_slot,
  input  logic [REG_W-1:0]              wdata,
  input  logic [$clog2(NUM_CTRL)-1:0]   rd_idx,
  output logic [REG_W-1:0]              rd_val
);
  logic [REG_W-1:0]          regs [NUM_CTRL];
  logic [NUM_CTRL*REG_W-1:0] regs_flat;
  logic                      unused_status_we;

  assign unused_status_we = wr_slot[SLOT_STATUS];

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
    if (i == SLOT_STATUS) begin : g_status
      assign regs[i] = STATUS_VALUE;
    end else if (i == SLOT_POWER) begin : g_power
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          q <= '0;
        else if (wr_slot[i]) q <= power_fix(wdata);
      end
      assign regs[i] = q;
    end else begin : g_plain
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          q <= '0;
        else if (wr_slot[i]) q <= wdata;
      end
      assign regs[i] = q;
    end
    assign regs_flat[i*REG_W +: REG_W] = regs[i];
  end

  assign rd_val = regs[rd_idx];

  // R4: forced bits after a trigger write
  p_power_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_slot[SLOT_POWER] && wdata[PWR_TRIG_BIT] |=> (regs[SLOT_POWER] & PWR_FORCE) == PWR_FORCE);
  // R4: plain store when trigger bit is clear
  p_power_plain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_slot[SLOT_POWER] && !wdata[PWR_TRIG_BIT] |=> regs[SLOT_POWER] == $past(wdata));
  // R5, R11: nothing moves without a strobe to a storing slot
  p_ctrl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_slot & ~(NUM_CTRL'(1) << SLOT_STATUS)) == '0 |=> $stable(regs_flat));
endmodule

// File: rtl/gcr_gpio_core.sv
module gcr_gpio_core
  import gcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_we,
  input  logic             lvl_we,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] pins_sync,
  output logic [REG_W-1:0] dir_q,
  output logic [REG_W-1:0] level_q,
  output logic [REG_W-1:0] out_q
);
  logic [REG_W-1:0] seen_q;
  logic [REG_W-1:0] pin_chg;
  logic [REG_W-1:0] level_d;
  logic [REG_W-1:0] dir_d;
  logic [REG_W-1:0] out_next;
  logic [REG_W-1:0] upd_bits;
  logic             refresh;

  assign pin_chg  = pins_sync ^ seen_q;
  assign dir_d    = dir_we ? wdata : dir_q;
  assign level_d  = lvl_we ? dir_mask(wdata, dir_q)
                           : apply_edges(level_q, pins_sync, pin_chg);
  assign refresh  = dir_we || lvl_we;
  assign out_next = dir_mask(level_d, dir_d);
  assign upd_bits = refresh ? (out_q ^ out_next) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= '0;
      dir_q   <= '0;
      level_q <= '0;
      out_q   <= '0;
    end else begin
      seen_q  <= pins_sync;
      dir_q   <= dir_d;
      level_q <= level_d;
      out_q   <= out_q ^ upd_bits;
    end
  end

  p_level_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_we |=> (level_q & ~dir_q) == '0);
  p_out_refresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> out_q == (level_q & dir_q));
  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh |=> $stable(out_q));
  p_input_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_we |=> ((level_q ^ $past(pins_sync)) & $past(pin_chg)) == '0);
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_we |=> level_q == ($past(wdata) & $past(dir_q)));
  p_dir_no_remask_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dir_we && !lvl_we && pin_chg == '0 |=> $stable(level_q));
endmodule

// File: rtl/gpio_companion_regs.sv
module gpio_companion_regs
  import gcr_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [REG_W-1:0]  gpio_in,
  output logic [REG_W-1:0]  gpio_out
);
  localparam int CTRL_IDX_W = $clog2(NUM_CTRL);

  logic [REG_W-1:0]     wdata16;
  logic                 rd_hit;
  logic [SLOT_W-1:0]    slot;
  logic [NUM_SLOTS-1:0] wr_slot;
  logic [REG_W-1:0]     ctrl_val;
  logic [REG_W-1:0]     dir_q;
  logic [REG_W-1:0]     level_q;
  logic [REG_W-1:0]     pins_sync;
  logic                 lvl_we;
  logic                 unused_hi;

  assign wdata16   = bus_wdata[REG_W-1:0];
  assign unused_hi = ^{bus_addr[ADDR_W-1:6], bus_wdata[DATA_W-1:REG_W]};

  gcr_decode u_decode (
    .off     (bus_addr[5:0]),
    .we      (bus_we),
    .hit     (rd_hit),
    .slot    (slot),
    .wr_slot (wr_slot)
  );

  gcr_ctrl_regs u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_slot (wr_slot[NUM_CTRL-1:0]),
    .wdata   (wdata16),
    .rd_idx  (slot[CTRL_IDX_W-1:0]),
    .rd_val  (ctrl_val)
  );

  gcr_sync #(.W(REG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (gpio_in),
    .dout  (pins_sync)
  );

  assign lvl_we = wr_slot[SLOT_LEVEL_A] || wr_slot[SLOT_LEVEL_B];

  gcr_gpio_core u_gpio (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_we    (wr_slot[SLOT_DIR]),
    .lvl_we    (lvl_we),
    .wdata     (wdata16),
    .pins_sync (pins_sync),
    .dir_q     (dir_q),
    .level_q   (level_q),
    .out_q     (gpio_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      if (slot < SLOT_W'(NUM_CTRL))              bus_rdata = ctrl_val;
      else if (slot == SLOT_W'(SLOT_DIR))        bus_rdata = dir_q;
      else                                       bus_rdata = level_q;
    end
  end

  // R5: fixed status value seen at the port
  p_status_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit && slot == SLOT_W'(SLOT_STATUS) |-> bus_rdata == STATUS_VALUE);
  // R6: both level aliases return the same word
  p_level_alias_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit && (slot == SLOT_W'(SLOT_LEVEL_A) || slot == SLOT_W'(SLOT_LEVEL_B)) |-> bus_rdata == level_q);
endmodule

// File: tb/test_gpio_companion_regs.sv
`timescale 1ns/1ps
module test_gpio_companion_regs;
  localparam real CLK_NS = 20.0;
  localparam int  NV     = 33;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] gpio_in = '0;
  logic [15:0] gpio_out;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  gpio_companion_regs i_gpio_companion_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(gpio_in), .gpio_out(gpio_out)
  );

  // {we, addr, wdata, expected read, requirement number}
  localparam logic [64:0] VEC [NV] = '{
    {1'b1, 12'h000, 32'h1234ABCD, 16'h0000, 4'd3},  // R3
    {1'b0, 12'h000, 32'h0,        16'hABCD, 4'd3},
    {1'b1, 12'h004, 32'hFFFF0055, 16'h0000, 4'd3},
    {1'b0, 12'h004, 32'h0,        16'h0055, 4'd3},
    {1'b1, 12'h010, 32'h0000BEEF, 16'h0000, 4'd3},
    {1'b0, 12'h010, 32'h0,        16'hBEEF, 4'd3},
    {1'b1, 12'h014, 32'h00001111, 16'h0000, 4'd3},
    {1'b0, 12'h014, 32'h0,        16'h1111, 4'd3},
    {1'b1, 12'h018, 32'h00002222, 16'h0000, 4'd3},
    {1'b0, 12'h018, 32'h0,        16'h2222, 4'd3},
    {1'b1, 12'h01C, 32'h00003333, 16'h0000, 4'd3},
    {1'b0, 12'h01C, 32'h0,        16'h3333, 4'd3},
    {1'b1, 12'h00C, 32'h00000080, 16'h0000, 4'd4},  // R4
    {1'b0, 12'h00C, 32'h0,        16'h80C0, 4'd4},
    {1'b1, 12'h00C, 32'h00000041, 16'h0000, 4'd4},
    {1'b0, 12'h00C, 32'h0,        16'h0041, 4'd4},
    {1'b1, 12'h008, 32'h0000FFFF, 16'h0000, 4'd5},  // R5
    {1'b0, 12'h008, 32'h0,        16'h0002, 4'd5},
    {1'b1, 12'h840, 32'h00007777, 16'h0000, 4'd2},  // R2
    {1'b0, 12'h000, 32'h0,        16'h7777, 4'd2},
    {1'b0, 12'hFC0, 32'h0,        16'h7777, 4'd2},
    {1'b1, 12'h02C, 32'h00009999, 16'h0000, 4'd11}, // R11
    {1'b0, 12'h02C, 32'h0,        16'h0000, 4'd11},
    {1'b0, 12'h001, 32'h0,        16'h0000, 4'd11},
    {1'b1, 12'h002, 32'h00005555, 16'h0000, 4'd11},
    {1'b0, 12'h000, 32'h0,        16'h7777, 4'd11},
    {1'b1, 12'h020, 32'h000000FF, 16'h0000, 4'd6},  // R6
    {1'b0, 12'h020, 32'h0,        16'h00FF, 4'd6},
    {1'b1, 12'h024, 32'h0000ABCD, 16'h0000, 4'd6},
    {1'b0, 12'h028, 32'h0,        16'h00CD, 4'd6},
    {1'b0, 12'h024, 32'h0,        16'h00CD, 4'd6},
    {1'b1, 12'h028, 32'h00000F0F, 16'h0000, 4'd6},
    {1'b0, 12'h024, 32'h0,        16'h000F, 4'd6}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 v = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state of every decoded offset and the pins
    for (int o = 0; o <= 'h28; o += 4) begin
      rd(12'(o), v);
      check("R1", v, (o == 8) ? 16'h0002 : 16'h0000);
    end
    check("R1", gpio_out, 16'h0000);

    // table of writes and reads
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][64]) begin
        wr(VEC[i][63:52], VEC[i][51:20]);
      end else begin
        rd(VEC[i][63:52], v);
        check($sformatf("R%0d table[%0d]", VEC[i][3:0], i), v, VEC[i][19:4]);
      end
    end

    // R7: outputs after the last level write (level 0x000F, dir 0x00FF)
    check("R7", gpio_out, 16'h000F);
    // R12: narrowing the direction leaves level alone; R7 refresh
    wr(12'h020, 32'h0003);
    rd(12'h024, v);
    check("R12", v, 16'h000F);
    check("R7", gpio_out, 16'h0003);

    // R9: pin rises, level follows regardless of direction; R8: pins hold
    @(negedge clk); gpio_in = 16'h8000;
    idle(5);
    rd(12'h028, v);
    check("R9", v, 16'h800F);
    check("R8", gpio_out, 16'h0003);
    wr(12'h020, 32'hFFFF);
    check("R7", gpio_out, 16'h800F);

    // R10: bus write to level lands on the same edge as the pin update
    @(negedge clk); gpio_in = 16'h8010;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 12'h024; bus_we = 1'b1; bus_wdata = 32'h0;
    @(negedge clk);
    bus_we = 1'b0;
    idle(5);
    rd(12'h024, v);
    check("R10", v, 16'h0000);
    check("R10", gpio_out, 16'h0000);

    // R9: a falling pin clears its level bit
    wr(12'h024, 32'hFFFF);
    @(negedge clk); gpio_in = 16'h0010;
    idle(5);
    rd(12'h024, v);
    check("R9", v, 16'h7FFF);
    check("R8", gpio_out, 16'hFFFF);

    finish_run();
  end
endmodule